// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

A binary up-counter of parameterised width (four bits by default, so it counts modulo 16) that advances on the rising clock edge. A low on the load input copies a parallel data word into the count on the next edge. Counting needs two enables together: a broadside enable shared by every stage of a chain, and a carry-in enable fed from the stage below. The carry-out output is high only when the carry-in enable is high and the count is all ones. It is combinational, so a long chain of stages carries in the same clock cycle, with no ripple through registers.

The clear input is active low. A compile-time parameter picks how it acts. In asynchronous mode the count drops to zero at once and stays there while the clear is held low. In synchronous mode the count drops to zero only at a rising edge. In both modes the clear beats load and both enables. To build a wider counter, chain instances: each stage's carry-in enable takes the carry-out of the stage below, and the clock, clear, load and broadside enable are shared by all stages.

Top module: `sync_preset_counter`

## Requirements
- R1: With clear and load inactive (high) and both enables high, the count rises by one on each rising edge, in plain binary, and wraps from all ones to zero.
- R2: With clear and load high, a low on either enable holds the count through the edge.
- R3: With clear high and load low, the next rising edge copies `din` into `count` (bit 0 is the least significant bit), whatever the enables are.
- R4: With `RESET_SYNC` = 1, a low clear sets the count to zero at the next rising edge and overrides load and both enables. Between edges the count does not change.
- R5: With `RESET_SYNC` = 0, a low clear forces the count to zero at once, with no clock edge, and holds it there. The first edge after the clear is released acts normally on load and the enables.
- R6: `carry_out` is high exactly when `en_trk` is high and the count is all ones. It does not depend on `en_par` or `load_n`, and it follows `en_trk` with no clock edge.
- R7: Stages chained with each `carry_out` driving the next stage's `en_trk` behave as one wide binary counter: loads, holds and wraps happen with no missed and no doubled carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per `RESET_SYNC` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Broadside count enable |
| en_trk | input | 1 | Carry-in count enable; also gates `carry_out` |
| din | input | WIDTH | Parallel load data, bit 0 least significant |
| count | output | WIDTH | Present count |
| carry_out | output | 1 | Terminal-count carry to the next stage |

## Verification
The single synchronous-clear instance is run free through a full wrap. It is also driven with each enable low alone, with a load while the enables are low, and with clear and load low together, which separates the four modes and shows that their priority holds. A three-stage chain with asynchronous clear is loaded just below the 8-bit and 12-bit carry boundaries and run across them, which exposes any missed or doubled carry. On that same chain the clear is dropped between edges, which shows that the clear acts at once. The carry output is toggled through `en_trk` while the clock stands still, and `en_par` is changed while the count sits at all ones, which shows that the carry is combinational and which inputs gate it.

// File: rtl/cnt_pkg.sv
// Package: shared operation encoding for the presettable counter.
// Assumes: the operation is a priority decode made once per cycle.
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_select.sv
// Module: picks this cycle's operation with a fixed priority:
// clear, then load, then count, then hold.
// Assumes: all controls are active levels sampled at the rising edge.
module cnt_op_select
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);
    // Priority decode of the mode controls.
    always_comb begin
        if (!clr_n)                op = OP_CLEAR;
        else if (!load_n)          op = OP_LOAD;
        else if (en_par && en_trk) op = OP_COUNT;
        else                       op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_next.sv
// Module: works out the next count from the chosen operation.
// Assumes: the incrementer wraps from all ones to zero.
module cnt_next
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] toggle;
    logic [WIDTH-1:0] incr;

    // Per-bit toggle chain: bit i flips when every lower bit is one.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign toggle[i] = 1'b1;
        end else begin : g_upper
            assign toggle[i] = toggle[i-1] & cur[i-1];
        end
        assign incr[i] = cur[i] ^ toggle[i];
    end

    // Route the next value by operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = incr;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_state.sv
// Module: the count register, with an asynchronous or a synchronous clear.
// Assumes: in synchronous mode the clear already reaches nxt as zero.
module cnt_state #(
    parameter int WIDTH      = 4,
    parameter bit RESET_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    if (RESET_SYNC) begin : g_sync
        // Edge-only update; the clear arrives through nxt.
        always_ff @(posedge clk) begin
            q <= nxt;
        end
    end else begin : g_async
        // Asynchronous clear overrides the clock.
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q <= '0;
            else        q <= nxt;
        end
    end
endmodule

// File: rtl/cnt_carry.sv
// Module: decodes the terminal-count carry, fully and combinationally.
// Assumes: only the carry-in enable gates the carry.
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic             en_trk,
    input  logic [WIDTH-1:0] q,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TERM = '1;

    // Carry is high in the single all-ones state when enabled.
    always_comb begin
        tc = en_trk && (q == TERM);
    end
endmodule

// File: rtl/sync_preset_counter.sv
// Module: top of the cascadable presettable up-counter.
// Assumes: RESET_SYNC = 0 gives an asynchronous clear, 1 a synchronous one;
// chained stages share clk, clr_n, load_n and en_par.
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit RESET_SYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    cnt_op_select u_sel (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    cnt_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (count),
        .din (din),
        .nxt (nxt)
    );

    cnt_state #(.WIDTH(WIDTH), .RESET_SYNC(RESET_SYNC)) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .q     (count)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .en_trk (en_trk),
        .q      (count),
        .tc     (carry_out)
    );
endmodule

// File: rtl/sync_preset_counter_chk.sv
// Checker: temporal properties of the counter, bound to every instance.
// Assumes: the clear is applied before the first edge.
module sync_preset_counter_chk #(
    parameter int WIDTH      = 4,
    parameter bit RESET_SYNC = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (count == WIDTH'($past(count) + 1'b1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));

    assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (count == $past(din)));

    assert_carry_gate_R6: assert property (@(posedge clk)
        carry_out |-> (en_trk && (&count)));

    assert_carry_full_R6: assert property (@(posedge clk)
        (en_trk && (&count)) |-> carry_out);

    if (RESET_SYNC) begin : g_sync_chk
        assert_sync_clear_R4: assert property (@(posedge clk)
            (!clr_n) |=> (count == '0));
    end else begin : g_async_chk
        assert_async_clear_R5: assert property (@(posedge clk)
            (!clr_n) |-> (count == '0));
    end
endmodule

bind sync_preset_counter sync_preset_counter_chk #(
    .WIDTH      (WIDTH),
    .RESET_SYNC (RESET_SYNC)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .din       (din),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/sync_preset_counter_test.sv
// Bench: one synchronous-clear instance (uut) and a three-stage
// asynchronous-clear chain, both compared against behavioural models.
module sync_preset_counter_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // uut controls and outputs
    logic       clr_n = 1'b0, load_n = 1'b1, ep = 1'b0, et = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] q;
    logic       tc;

    // chain controls and outputs
    logic        c_clr_n = 1'b0, c_load_n = 1'b1, c_ep = 1'b0, c_et = 1'b0;
    logic [11:0] c_din = '0;
    logic [11:0] c_q;
    logic [2:0]  c_tc;
    logic [2:0]  c_en;

    sync_preset_counter #(.WIDTH(4), .RESET_SYNC(1'b1)) uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(ep), .en_trk(et),
        .din(din), .count(q), .carry_out(tc)
    );

    for (genvar k = 0; k < 3; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign c_en[k] = c_et;
        end else begin : g_rest
            assign c_en[k] = c_tc[k-1];
        end
        sync_preset_counter #(.WIDTH(4), .RESET_SYNC(1'b0)) u_st (
            .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .en_par(c_ep),
            .en_trk(c_en[k]), .din(c_din[4*k +: 4]), .count(c_q[4*k +: 4]),
            .carry_out(c_tc[k])
        );
    end

    // Reference models
    int    m  = 0;
    int    cm = 0;
    string utag = "R4";
    string ctag = "R5";

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance both models at each edge, then compare after the outputs settle.
    always @(posedge clk) begin
        if (!clr_n)            begin m = 0;             utag = "R4"; end
        else if (!load_n)      begin m = int'(din);     utag = "R3"; end
        else if (ep && et)     begin m = (m + 1) % 16;  utag = "R1"; end
        else                   begin                    utag = "R2"; end
        if (!c_clr_n)          begin cm = 0;            ctag = "R5"; end
        else if (!c_load_n)    begin cm = int'(c_din);  ctag = "R3"; end
        else if (c_ep && c_et) begin cm = (cm + 1) % 4096; ctag = "R7"; end
        else                   begin                    ctag = "R2"; end
        #5;
        if (!done) begin
            chk({utag, " uut count"}, int'(q), m);
            chk("R6 uut carry", int'(tc), int'(et && m == 15));
            chk({ctag, " chain count"}, int'(c_q), cm);
            chk("R7 chain carry", int'(c_tc[2]), int'(c_et && cm == 4095));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(2);
        // Reset state, both clear modes (R4, R5)
        chk("R4 reset state", int'(q), 0);
        chk("R5 reset state", int'(c_q), 0);
        clr_n = 1'b1; c_clr_n = 1'b1;
        ep = 1'b1; et = 1'b1; c_ep = 1'b1; c_et = 1'b1;
        // R1: free count through a wrap
        tick(20);
        // R2: hold with each enable low
        ep = 1'b0; tick(3);
        ep = 1'b1; et = 1'b0; tick(3);
        et = 1'b1;
        c_ep = 1'b0; tick(2); c_ep = 1'b1;
        // R3: load while enables are low
        ep = 1'b0; et = 1'b0; load_n = 1'b0; din = 4'b1001; tick(1);
        chk("R3 load ignores enables", int'(q), 9);
        load_n = 1'b1; ep = 1'b1; et = 1'b1;
        // R7: chain across the 8-bit and 12-bit carry boundaries
        c_load_n = 1'b0; c_din = 12'h0FD; tick(1);
        c_load_n = 1'b1; tick(5);
        chk("R7 chain crossed 0FF", int'(c_q), 12'h102);
        c_load_n = 1'b0; c_din = 12'hFFC; tick(1);
        c_load_n = 1'b1; tick(6);
        chk("R7 chain wrapped", int'(c_q), 12'h002);
        // R6: carry follows en_trk with the clock's state unchanged
        ep = 1'b0; load_n = 1'b0; din = 4'hF; tick(1);
        load_n = 1'b1;
        #2; et = 1'b0; #1; chk("R6 carry drops with en_trk", int'(tc), 0);
        et = 1'b1; #1; chk("R6 carry rises with en_trk", int'(tc), 1);
        load_n = 1'b0; din = 4'hF; #1;
        chk("R6 carry ignores load and en_par", int'(tc), 1);
        tick(1); load_n = 1'b1; ep = 1'b1;
        tick(3);
        // R4: sync clear waits for the edge, beats load
        #2; clr_n = 1'b0; load_n = 1'b0; din = 4'h7; #1;
        chk("R4 no change before edge", int'(q), m);
        tick(1);
        chk("R4 clear beats load", int'(q), 0);
        clr_n = 1'b1; load_n = 1'b1; tick(2);
        // R5: async clear acts between edges, then normal operation
        #2; c_clr_n = 1'b0; c_load_n = 1'b0; c_din = 12'h555; #1;
        chk("R5 immediate clear", int'(c_q), 0);
        cm = 0;
        tick(2);
        c_clr_n = 1'b1; tick(1);
        chk("R5 load after release", int'(c_q), 12'h555);
        c_load_n = 1'b1; tick(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule